// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real address by walking a radix translation tree held in memory. A request supplies the address, a process id and a process-table base register, together with flags for store, instruction fetch and privileged access. The walker first reads the process table entry for that process. From that entry it takes the tree size, the root directory base and the root index width. It then checks that the address lies inside the tree. After that it walks the directory levels, one memory read per level, until it reaches a leaf entry.

At the leaf it checks permissions and the reference/change bits. It then signals completion with either the real address or exactly one error flag. Each level reads its own index width from a 5-bit size field in the entry it came from, so the tree depth is not fixed. Every table address is built by merging selected address bits into the table base under a mask.

Memory is reached through a 64-bit read port. Requests use a valid/ready handshake and each response is marked by a response-valid strobe. Only one read is ever in flight.

Top module: `radix_walker`

## Requirements
- R1: The process-table read address is {8'b0, base[55:36], (base[35:12] & ~M) | (pid[31:8] & M), pid[7:0], 4'b0}. Here M is a 24-bit mask whose low N bits are set, and N is base register bits 4..0.
- R2: When effective address bit 63 is 1, the process id used in R1 is zero.
- R3: The process table entry gives the tree size as {bits 62..61, bits 7..5}, the root base as bits 55..8 followed by 8 zero bits, and the root index width as bits 4..0. The check fails when address bit 63 differs from bit 62, or when any of address bits 61..31 is set at a position at or above the tree size. On failure the walk ends with the segment error.
- R4: A root index width below 5, above 16, or above the tree size plus 19 ends the walk with the bad-tree error. Otherwise the remaining shift becomes tree size + 19 - width.
- R5: Each directory read address is {8'b0, base[55:19], (base[18:3] & ~L) | (S & L), 3'b0}. S is the low 16 bits of address bits 61..12 shifted right by the remaining shift, and L has the low "index width" bits set.
- R6: In every entry bit 63 is valid and bit 62 is leaf. A non-leaf entry whose width field (bits 4..0) is below 5, above 16 or above the remaining shift gives the bad-tree error. Otherwise the shift is reduced by that width, and the walk continues with base = bits 55..8 followed by 8 zero bits.
- R7: An entry read during the directory walk with bit 63 clear ends the walk with the invalid-entry error.
- R8: At a leaf the result is {8'b0, (entry[55:12] & ~F) | (ea[55:12] & F), entry[11:0]}, where F has the low "remaining shift" bits set.
- R9: A leaf with bit 3 set denies unprivileged access. A fetch needs bit 0 set and bit 5 clear. A load needs bit 1 or bit 2. A store needs bit 1. A failure gives the permission error.
- R10: With permission granted, the leaf needs bit 8 set, and bit 7 set for a store, or the walk ends with the reference/change error. A permission failure takes precedence over this error.
- R11: Completion is a one-cycle done pulse with at most one error flag set. A request is accepted only while req_ready is high, and a request offered during a walk is ignored.
- R12: A memory request holds its address stable until accepted, and no new request is raised while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High while idle and able to take a request |
| req_ea | input | 64 | Effective address to translate |
| req_pid | input | 32 | Process id |
| req_ptbr | input | 64 | Process-table base register (base in 55..12, size in 4..0) |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_priv | input | 1 | Access is privileged |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the 64-bit word to read |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| real_addr | output | 64 | Translated result, valid with done when no error is set |
| err_invalid | output | 1 | Invalid entry met |
| err_badtree | output | 1 | Index width out of range |
| err_segment | output | 1 | Address outside the tree |
| err_perm | output | 1 | Permission denied |
| err_rc | output | 1 | Reference/change bits insufficient |

## Verification
The checker watches the memory port on every cycle. It checks that a pending read holds its address, that no second read is raised while one is in flight, and that every table address has zero top byte and 8-byte alignment. It also checks that done is a single-cycle pulse with at most one error flag, and that an accepted request drops req_ready at once. Address formation, pid forcing, the segment mask, the width bounds, the leaf merge and the permission and change rules can only be shown by the bench scenarios. Each scenario lays out a tree in the memory model, so a wrongly formed address reads an empty word and surfaces as a wrong result.

// File: rtl/radix_walker.sv
module radix_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_ea,
  input  logic [31:0] req_pid,
  input  logic [63:0] req_ptbr,
  input  logic        req_store,
  input  logic        req_fetch,
  input  logic        req_priv,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic [63:0] real_addr,
  output logic        err_invalid,
  output logic        err_badtree,
  output logic        err_segment,
  output logic        err_perm,
  output logic        err_rc
);

  typedef enum logic [2:0] {S_IDLE, S_PRT, S_SEG, S_LOOK, S_WAIT, S_FIN} state_t;

  state_t      state;
  logic [63:12] ea_q;
  logic [31:0] pid_q;
  logic [55:12] tb_q;
  logic [4:0]  ts_q;
  logic        st_q, fe_q, pv_q, root_rd;
  logic [5:0]  shift_q;
  logic [4:0]  msize_q;
  logic [47:0] base_q;
  logic [63:0] real_q;
  logic [4:0]  err_q;

  function automatic logic [43:0] lowmask(input logic [5:0] n);
    logic [43:0] m;
    for (int i = 0; i < 44; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  logic [43:0] prt_full, lvl_full, fin_m;
  logic [31:0] eff_pid;
  logic [63:0] prt_addr, pg_addr, leaf_ra;
  logic [49:0] ea_sh;
  logic [15:0] lvl_m;
  logic        seg_bad, perm_ok, rc_ok, nl_bad;
  logic [6:0]  root_lim;
  logic [4:0]  nm;
  logic [63:0] d;

  assign d        = mem_rsp_data;
  assign eff_pid  = ea_q[63] ? 32'd0 : pid_q;
  assign prt_full = lowmask({1'b0, ts_q});
  assign prt_addr = {8'h0, tb_q[55:36],
                     (tb_q[35:12] & ~prt_full[23:0]) | (eff_pid[31:8] & prt_full[23:0]),
                     eff_pid[7:0], 4'h0};

  assign ea_sh    = ea_q[61:12] >> shift_q;
  assign lvl_full = lowmask({1'b0, msize_q});
  assign lvl_m    = lvl_full[15:0];
  assign pg_addr  = {8'h0, base_q[47:11],
                     ({base_q[10:0], 5'h0} & ~lvl_m) | (ea_sh[15:0] & lvl_m), 3'h0};

  assign fin_m    = lowmask(shift_q);
  assign leaf_ra  = {8'h0, (d[55:12] & ~fin_m) | (ea_q[55:12] & fin_m), d[11:0]};

  assign seg_bad  = (ea_q[63] ^ ea_q[62]) | (|(ea_q[61:31] & ~fin_m[30:0]));
  assign root_lim = {1'b0, shift_q} + 7'd19;

  assign perm_ok  = (pv_q | ~d[3]) &
                    (fe_q ? (d[0] & ~d[5]) : (d[1] | (d[2] & ~st_q)));
  assign rc_ok    = d[8] & (d[7] | ~st_q);

  assign nm       = d[4:0];
  assign nl_bad   = (nm < 5'd5) | (nm > 5'd16) | ({1'b0, nm} > shift_q);

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_PRT) || (state == S_LOOK);
  assign mem_req_addr  = (state == S_PRT) ? prt_addr : pg_addr;
  assign done          = (state == S_FIN);
  assign real_addr     = real_q;
  assign {err_rc, err_perm, err_segment, err_badtree, err_invalid} = err_q;

  logic unused_bits;
  assign unused_bits = ^{req_ea[11:0], req_ptbr[63:56], req_ptbr[11:5], d[60:56]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ea_q    <= '0;
      pid_q   <= '0;
      tb_q    <= '0;
      ts_q    <= '0;
      st_q    <= 1'b0;
      fe_q    <= 1'b0;
      pv_q    <= 1'b0;
      root_rd <= 1'b0;
      shift_q <= '0;
      msize_q <= '0;
      base_q  <= '0;
      real_q  <= '0;
      err_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          ea_q   <= req_ea[63:12];
          pid_q  <= req_pid;
          tb_q   <= req_ptbr[55:12];
          ts_q   <= req_ptbr[4:0];
          st_q   <= req_store;
          fe_q   <= req_fetch;
          pv_q   <= req_priv;
          real_q <= '0;
          err_q  <= '0;
          state  <= S_PRT;
        end
        S_PRT: if (mem_req_ready) begin
          root_rd <= 1'b1;
          state   <= S_WAIT;
        end
        S_SEG: begin
          if (seg_bad) begin
            err_q <= 5'b00100;
            state <= S_FIN;
          end else if (msize_q < 5'd5 || msize_q > 5'd16 || {2'b0, msize_q} > root_lim) begin
            err_q <= 5'b00010;
            state <= S_FIN;
          end else begin
            shift_q <= 6'(root_lim - {2'b0, msize_q});
            state   <= S_LOOK;
          end
        end
        S_LOOK: if (mem_req_ready) begin
          root_rd <= 1'b0;
          state   <= S_WAIT;
        end
        S_WAIT: if (mem_rsp_valid) begin
          if (root_rd) begin
            shift_q <= {1'b0, d[62:61], d[7:5]};
            msize_q <= d[4:0];
            base_q  <= d[55:8];
            state   <= S_SEG;
          end else if (!d[63]) begin
            err_q <= 5'b00001;
            state <= S_FIN;
          end else if (d[62]) begin
            if (!perm_ok)     err_q  <= 5'b01000;
            else if (!rc_ok)  err_q  <= 5'b10000;
            else              real_q <= leaf_ra;
            state <= S_FIN;
          end else if (nl_bad) begin
            err_q <= 5'b00010;
            state <= S_FIN;
          end else begin
            shift_q <= shift_q - {1'b0, nm};
            msize_q <= nm;
            base_q  <= d[55:8];
            state   <= S_LOOK;
          end
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module radix_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        done,
  input logic        err_invalid,
  input logic        err_badtree,
  input logic        err_segment,
  input logic        err_perm,
  input logic        err_rc
);

  logic outstanding;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
    else if (mem_rsp_valid) outstanding <= 1'b0;
  end

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mem_req_valid);

  assert_addr_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[63:56] == 8'h0) && (mem_req_addr[2:0] == 3'h0));

  assert_single_error_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({err_invalid, err_badtree, err_segment, err_perm, err_rc}));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && mem_req_valid);

  assert_no_done_inflight_R12: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !done);

endmodule

bind radix_walker radix_walker_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .done(done),
  .err_invalid(err_invalid), .err_badtree(err_badtree), .err_segment(err_segment),
  .err_perm(err_perm), .err_rc(err_rc));

// File: tb/test_radix_walker.sv
module test_radix_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_ea = '0;
  logic [31:0] req_pid = '0;
  logic [63:0] req_ptbr = '0;
  logic        req_store = 1'b0, req_fetch = 1'b0, req_priv = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [63:0] real_addr;
  logic        err_invalid, err_badtree, err_segment, err_perm, err_rc;

  localparam logic [4:0] OK   = 5'b00000;
  localparam logic [4:0] EINV = 5'b00001;
  localparam logic [4:0] EBAD = 5'b00010;
  localparam logic [4:0] ESEG = 5'b00100;
  localparam logic [4:0] EPRM = 5'b01000;
  localparam logic [4:0] ERC  = 5'b10000;
  localparam logic [63:0] PTBR = 64'h0000_0000_0100_0004;

  int checks = 0, fails = 0;
  logic [68:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] tmem [logic [63:0]];

  always #5 clk = ~clk;

  radix_walker i_radix_walker (.*);

  initial begin : memory_model
    int delay = 0;
    int cyc = 0;
    logic [63:0] pend = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (delay > 0) begin
        delay--;
        if (delay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = tmem.exists(pend) ? tmem[pend] : 64'h0;
        end
      end
      mem_req_ready = rst_n && ((cyc % 3) != 1);
      if (mem_req_valid && mem_req_ready && delay == 0 && !mem_rsp_valid) begin
        pend  = mem_req_addr;
        delay = 2;
      end
    end
  end

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (done) begin
        logic [4:0] e;
        e = {err_rc, err_perm, err_segment, err_badtree, err_invalid};
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R11 unexpected done: got addr %h err %b, expected no completion", real_addr, e);
        end else begin
          logic [68:0] x;
          string t;
          x = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e != x[4:0] || (x[4:0] == OK && real_addr != x[68:5])) begin
            fails++;
            $display("FAIL %s: got addr %h err %b, expected addr %h err %b", t, real_addr, e, x[68:5], x[4:0]);
          end
        end
      end
    end
  end

  task automatic walk(input logic [63:0] ea, input logic [31:0] pid,
                      input bit st, input bit fe, input bit pv,
                      input logic [63:0] exp_a, input logic [4:0] exp_e,
                      input string tag, input bit poke = 1'b0);
    exp_q.push_back({exp_a, exp_e});
    tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_ea = ea; req_pid = pid; req_ptbr = PTBR;
    req_store = st; req_fetch = fe; req_priv = pv;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_ea = 64'h4000_0000_0000_0000; req_pid = 32'h306;
      req_valid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stimulus
    tmem[64'h1003050] = 64'h0000_0000_0003_0009;
    tmem[64'h1000000] = 64'h0000_0000_0005_0009;
    tmem[64'h1003060] = 64'h0000_0000_0003_0014;
    tmem[64'h1003070] = 64'h0000_0000_0003_0004;
    tmem[64'h1003080] = 64'h0000_0000_0003_0049;
    tmem[64'h30240]   = 64'h8000_0000_0004_000A;
    tmem[64'h41A28]   = 64'hC000_0000_ABCD_E187;
    tmem[64'h30008]   = 64'hC000_0000_0080_0187;
    tmem[64'h30018]   = 64'h8000_0000_0004_000B;
    tmem[64'h30020]   = 64'hC000_0000_0080_0180;
    tmem[64'h30028]   = 64'hC000_0000_0080_01A5;
    tmem[64'h30030]   = 64'hC000_0000_0080_0106;
    tmem[64'h30038]   = 64'hC000_0000_0080_018E;
    tmem[64'h30040]   = 64'hC000_0000_0080_0104;
    tmem[64'h50240]   = 64'hC000_0000_0DEF_0187;
    tmem[64'h30400]   = 64'hC000_0000_1234_5187;

    repeat (3) @(negedge clk);
    checks++;
    if (req_ready !== 1'b1 || done !== 1'b0 || mem_req_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: got ready %b done %b memvalid %b, expected 1 0 0", req_ready, done, mem_req_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b1 || {err_rc, err_perm, err_segment, err_badtree, err_invalid} !== 5'b0) begin
      fails++;
      $display("FAIL R11 idle after reset: got ready %b, expected 1", req_ready);
    end

    walk(64'h1234_5678, 32'h305, 0, 0, 0, 64'hABCD_E187, OK, "R1 R5 R6 R8 three-level load");
    walk(64'h1234_5678, 32'h305, 1, 0, 0, 64'hABCD_E187, OK, "R9 R10 three-level store");
    walk(64'h1234_5678, 32'h305, 0, 1, 0, 64'hABCD_E187, OK, "R9 three-level fetch");
    walk(64'h0040_1234, 32'h305, 0, 0, 0, 64'h0080_1187, OK, "R8 leaf at root level");
    walk(64'hC000_0000_1234_5678, 32'h305, 0, 0, 0, 64'h0DF4_5187, OK, "R2 pid forced zero");
    walk(64'h0080_0000, 32'h305, 0, 0, 0, 64'h0, EINV, "R7 invalid entry");
    walk(64'h4000_0000_0000_0000, 32'h305, 0, 0, 0, 64'h0, ESEG, "R3 top bits differ");
    walk(64'h8000_0000, 32'h305, 0, 0, 0, 64'h0, ESEG, "R3 bit31 outside size 0");
    walk(64'h8000_0000, 32'h308, 0, 0, 0, 64'h1200_0187, OK, "R3 R4 tree size 2 inside");
    walk(64'h2_0000_0000, 32'h308, 0, 0, 0, 64'h0, ESEG, "R3 tree size 2 outside");
    walk(64'h1000, 32'h306, 0, 0, 0, 64'h0, EBAD, "R4 root width 20");
    walk(64'h1000, 32'h307, 0, 0, 0, 64'h0, EBAD, "R4 root width 4");
    walk(64'h00C0_0000, 32'h305, 0, 0, 0, 64'h0, EBAD, "R6 width above shift");
    walk(64'h0100_0000, 32'h305, 0, 0, 0, 64'h0, EPRM, "R9 no access bits");
    walk(64'h0140_0000, 32'h305, 0, 1, 0, 64'h0, EPRM, "R9 fetch inhibited");
    walk(64'h0140_0000, 32'h305, 0, 0, 0, 64'h0080_01A5, OK, "R9 load read-only");
    walk(64'h0180_0000, 32'h305, 1, 0, 0, 64'h0, ERC, "R10 store change clear");
    walk(64'h0180_0000, 32'h305, 0, 0, 0, 64'h0080_0106, OK, "R10 load change clear");
    walk(64'h01C0_0000, 32'h305, 0, 0, 0, 64'h0, EPRM, "R9 privileged page user");
    walk(64'h01C0_0000, 32'h305, 0, 0, 1, 64'h0080_018E, OK, "R9 privileged page priv");
    walk(64'h0200_0000, 32'h305, 1, 0, 0, 64'h0, EPRM, "R10 perm over rc");
    walk(64'h1234_5678, 32'h305, 0, 0, 0, 64'hABCD_E187, OK, "R11 R12 busy request ignored", 1'b1);

    repeat (20) @(negedge clk);
    checks++;
    if (req_ready !== 1'b1 || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 final idle: got ready %b pending %0d, expected 1 0", req_ready, exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule